// File: doc/BRIEF.md
# EDO Page-Mode DRAM Access Controller

This controller sits between a simple host request port and an asynchronous DRAM array with extended-data-out page cycles. The host presents a flat word address, a write flag, write data and a byte-lane mask. The controller splits the address into a row half and a column half and drives both over one shared address bus. It drives the active-low row strobe, one active-low column strobe per byte lane, and an active-low write strobe. Read data comes back with a one-clock valid pulse, in the order the reads were accepted.

Once a row has been opened, the controller keeps the row strobe low. Any later request to the same row runs as a short column-only page cycle. A request to a different row closes the page, waits out the row precharge time and opens the new row. The open-page time is bounded: a page that has stayed open too long is closed even when no request is waiting. An external refresh request makes the controller close the open row and hold all strobes high for as long as the request stays asserted.

Every timing spacing is a parameter counted in clock cycles. The defaults suit a 100 MHz clock.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the row strobe, all column strobes and the write strobe are high (inactive), `busy` is 0 and `rd_valid` is 0.
- R2: When the row strobe falls, `dram_a` carries address bits [21:11]. When the column strobes fall, `dram_a` carries bits [10:0]. The column strobes fall only while the row strobe is low and at least T_RCD (2) cycles after it fell.
- R3: Each accepted read returns, in acceptance order, the word last written to its address as one `rd_data` value with a `rd_valid` pulse one cycle wide. The column strobes of a read rise no earlier than T_RAC (6) cycles after the row strobe fell and T_CAC (2) cycles after they fell.
- R4: A request to the row that is already open leaves the row strobe low, so the row strobe does not fall again.
- R5: A request to a different row raises the row strobe. The row strobe then stays high for at least T_RP (4) cycles before it falls for the new row.
- R6: A read drives all four column strobes low. A write drives low only the strobes whose bit in `req_be` is 1 (bit n guards data bits [9n+8:9n]). A write with `req_be` of 0 drives none of them. While a write strobe is low, `dram_dq_oe` is 1.
- R7: Between successive falls of the column strobes, they stay high for at least T_CP (1) cycle, and the falls are at least T_HPC (3) cycles apart.
- R8: The row strobe never stays low longer than T_RASP_MAX cycles. The controller closes an idle open page before that limit.
- R9: While `refresh_req` is 1, the controller closes any open row and keeps every strobe high, with `busy` at 1. After `refresh_req` drops, the next access opens its row again.
- R10: A request is taken only in a cycle where `busy` is 0. A request presented while `busy` is 1 has no effect on the array.
- R11: Once the row strobe has fallen, it stays low for at least T_RAS_MIN (6) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, taken when busy is 0 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in [21:11], column in [10:0] |
| req_wdata | input | 36 | Write data, four 9-bit lanes |
| req_be | input | 4 | Write lane enables |
| refresh_req | input | 1 | Refresh window request |
| busy | output | 1 | Controller cannot take a request |
| rd_data | output | 36 | Read data |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| dram_a | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 4 | Per-lane column strobes, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_dq_out | output | 36 | Data driven toward the array |
| dram_dq_oe | output | 1 | Enable for dram_dq_out |
| dram_dq_in | input | 36 | Data returned by the array |

## Verification
The assertions assume that the host holds `req` high for at most one cycle per intended request, and that the array returns stable data on `dram_dq_in` from the column strobe fall until the strobes rise again. The assertions also assume that `refresh_req` is not pulsed faster than the close sequence can react. The stimulus keeps to these assumptions. It waits for `busy` to be low before each accepted request, and it issues deliberately ignored requests only as single-cycle pulses while `busy` is high. It holds `refresh_req` for many cycles at a time. The bench array model updates its returned word at the strobe edges it observes and keeps it steady otherwise.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLOSE,
    ST_OPEN,
    ST_COL,
    ST_CASL,
    ST_HOLD
  } edo_state_t;

  // True when a span counter that restarts at 0 one cycle after an event
  // shows that at least 'span' cycles will have elapsed at the coming edge.
  function automatic logic reached(input int unsigned age, input int unsigned span);
    return (age + 32'd1) >= span;
  endfunction

endpackage

// File: rtl/edo_span_counter.sv
module edo_span_counter #(
  parameter int W          = 8,
  parameter int LIMIT      = 200,
  parameter bit START_FULL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] age
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= START_FULL ? LIM : '0;
    else if (clr)       age <= '0;
    else if (age < LIM) age <= age + 1'b1;
  end
endmodule

// File: rtl/edo_page_tracker.sv
module edo_page_tracker #(
  parameter int ROW_W     = 11,
  parameter int AGE_W     = 8,
  parameter int EXPIRE_AT = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_evt,
  input  logic             close_evt,
  input  logic [ROW_W-1:0] open_row_in,
  input  logic [ROW_W-1:0] req_row,
  input  logic [AGE_W-1:0] ras_age,
  output logic             page_open,
  output logic             hit,
  output logic             expire
);
  logic [ROW_W-1:0] open_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_open <= 1'b0;
      open_row  <= '0;
    end else if (open_evt) begin
      page_open <= 1'b1;
      open_row  <= open_row_in;
    end else if (close_evt) begin
      page_open <= 1'b0;
    end
  end

  assign expire = page_open && (32'(ras_age) >= EXPIRE_AT);
  assign hit    = page_open && (req_row == open_row) && !expire;

  AST_OPEN_CLOSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(open_evt && close_evt)); // R5
  AST_CLOSE_NEEDS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |-> page_open); // R5
endmodule

// File: rtl/edo_read_return.sv
module edo_read_return #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= capture;
      if (capture) rdata <= dq_in;
    end
  end

  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid); // R3
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W      = 11,
  parameter int COL_W      = 11,
  parameter int DATA_W     = 36,
  parameter int LANES      = 4,
  parameter int T_RCD      = 2,
  parameter int T_RAC      = 6,
  parameter int T_CAC      = 2,
  parameter int T_CAS      = 2,
  parameter int T_CP       = 1,
  parameter int T_HPC      = 3,
  parameter int T_RP       = 4,
  parameter int T_RAS_MIN  = 6,
  parameter int T_RASP_MAX = 9000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req,
  input  logic                              req_we,
  input  logic [ROW_W+COL_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]                 req_wdata,
  input  logic [LANES-1:0]                  req_be,
  input  logic                              refresh_req,
  output logic                              busy,
  output logic [DATA_W-1:0]                 rd_data,
  output logic                              rd_valid,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_a,
  output logic                              dram_ras_n,
  output logic [LANES-1:0]                  dram_cas_n,
  output logic                              dram_we_n,
  output logic [DATA_W-1:0]                 dram_dq_out,
  output logic                              dram_dq_oe,
  input  logic [DATA_W-1:0]                 dram_dq_in
);
  localparam int ADDR_W    = ROW_W + COL_W;
  localparam int MUX_W     = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int LIMIT     = T_RASP_MAX + 1;
  localparam int AGE_W     = $clog2(LIMIT + 1);
  localparam int GUARD     = T_RAC + T_CAS + T_HPC + T_CP + 4;
  localparam int EXPIRE_AT = T_RASP_MAX - GUARD;

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:COL_W];
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  function automatic logic [LANES-1:0] lane_select(input logic w, input logic [LANES-1:0] b);
    return w ? b : {LANES{1'b1}};
  endfunction

  edo_state_t         st;
  logic               pend;
  logic               cur_we;
  logic [ROW_W-1:0]   cur_row;
  logic [COL_W-1:0]   cur_col;
  logic [LANES-1:0]   cur_be;
  logic [DATA_W-1:0]  cur_wdata;
  logic               ras_n_q;
  logic [LANES-1:0]   cas_n_q;
  logic               we_n_q;
  logic [MUX_W-1:0]   a_q;
  logic [DATA_W-1:0]  dq_out_q;
  logic               oe_q;

  logic [AGE_W-1:0]   ras_age, rp_age, cas_hi_age, cas_lo_age, cas_fall_age;
  logic               cas_all_hi;
  logic               page_open, hit, expire;

  // Named internal events used by the FSM and the assertions.
  logic               open_evt, close_evt, cas_issue, cas_done, rd_capture;

  assign cas_all_hi = &cas_n_q;

  edo_span_counter #(.W(AGE_W), .LIMIT(LIMIT), .START_FULL(1'b0)) u_ras_age (
    .clk(clk), .rst_n(rst_n), .clr(ras_n_q), .age(ras_age));
  edo_span_counter #(.W(AGE_W), .LIMIT(LIMIT), .START_FULL(1'b1)) u_rp_age (
    .clk(clk), .rst_n(rst_n), .clr(!ras_n_q), .age(rp_age));
  edo_span_counter #(.W(AGE_W), .LIMIT(LIMIT), .START_FULL(1'b1)) u_cas_hi_age (
    .clk(clk), .rst_n(rst_n), .clr(!cas_all_hi), .age(cas_hi_age));
  edo_span_counter #(.W(AGE_W), .LIMIT(LIMIT), .START_FULL(1'b0)) u_cas_lo_age (
    .clk(clk), .rst_n(rst_n), .clr(st != ST_CASL), .age(cas_lo_age));
  edo_span_counter #(.W(AGE_W), .LIMIT(LIMIT), .START_FULL(1'b1)) u_cas_fall_age (
    .clk(clk), .rst_n(rst_n), .clr(cas_issue), .age(cas_fall_age));

  edo_page_tracker #(.ROW_W(ROW_W), .AGE_W(AGE_W), .EXPIRE_AT(EXPIRE_AT)) u_page (
    .clk(clk), .rst_n(rst_n), .open_evt(open_evt), .close_evt(close_evt),
    .open_row_in(cur_row), .req_row(row_of(req_addr)), .ras_age(ras_age),
    .page_open(page_open), .hit(hit), .expire(expire));

  assign open_evt  = (st == ST_OPEN)  && reached(32'(rp_age), T_RP);
  assign close_evt = (st == ST_CLOSE) && reached(32'(ras_age), T_RAS_MIN);
  assign cas_issue = (st == ST_COL) && reached(32'(ras_age), T_RCD)
                   && reached(32'(cas_hi_age), T_CP) && reached(32'(cas_fall_age), T_HPC);
  assign cas_done  = (st == ST_CASL) && reached(32'(cas_lo_age), T_CAS)
                   && (cur_we || (reached(32'(cas_lo_age), T_CAC)
                                  && reached(32'(ras_age), T_RAC)));
  assign rd_capture = cas_done && !cur_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pend      <= 1'b0;
      cur_we    <= 1'b0;
      cur_row   <= '0;
      cur_col   <= '0;
      cur_be    <= '0;
      cur_wdata <= '0;
      ras_n_q   <= 1'b1;
      cas_n_q   <= '1;
      we_n_q    <= 1'b1;
      a_q       <= '0;
      dq_out_q  <= '0;
      oe_q      <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (refresh_req) begin
            pend <= 1'b0;
            st   <= page_open ? ST_CLOSE : ST_HOLD;
          end else if (req) begin
            cur_we    <= req_we;
            cur_row   <= row_of(req_addr);
            cur_col   <= col_of(req_addr);
            cur_be    <= req_be;
            cur_wdata <= req_wdata;
            if (hit) begin
              st <= ST_COL;
            end else if (page_open) begin
              pend <= 1'b1;
              st   <= ST_CLOSE;
            end else begin
              st <= ST_OPEN;
            end
          end else if (expire) begin
            pend <= 1'b0;
            st   <= ST_CLOSE;
          end
        end
        ST_CLOSE: begin
          if (close_evt) begin
            ras_n_q <= 1'b1;
            st      <= pend ? ST_OPEN : ST_IDLE;
          end
        end
        ST_OPEN: begin
          if (open_evt) begin
            ras_n_q <= 1'b0;
            a_q     <= MUX_W'(cur_row);
            st      <= ST_COL;
          end
        end
        ST_COL: begin
          if (cas_issue) begin
            cas_n_q  <= ~lane_select(cur_we, cur_be);
            we_n_q   <= ~cur_we;
            oe_q     <= cur_we;
            dq_out_q <= cur_wdata;
            a_q      <= MUX_W'(cur_col);
            st       <= ST_CASL;
          end
        end
        ST_CASL: begin
          if (cas_done) begin
            cas_n_q <= '1;
            we_n_q  <= 1'b1;
            oe_q    <= 1'b0;
            pend    <= 1'b0;
            st      <= ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (!refresh_req) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  edo_read_return #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .capture(rd_capture), .dq_in(dram_dq_in),
    .rdata(rd_data), .rvalid(rd_valid));

  assign busy        = (st != ST_IDLE) || refresh_req;
  assign dram_a      = a_q;
  assign dram_ras_n  = ras_n_q;
  assign dram_cas_n  = cas_n_q;
  assign dram_we_n   = we_n_q;
  assign dram_dq_out = dq_out_q;
  assign dram_dq_oe  = oe_q;

  AST_RCD_MET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_all_hi && $past(cas_all_hi)) |-> (!ras_n_q && 32'(ras_age) >= T_RCD)); // R2
  AST_RP_MET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_q) |-> (32'(rp_age) >= T_RP)); // R5
  AST_RAS_MIN_MET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_q) |-> (32'(ras_age) >= T_RAS_MIN)); // R11
  AST_PAGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n_q |-> (32'(ras_age) < T_RASP_MAX)); // R8
  AST_HIT_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && req && !refresh_req && hit) |=> !ras_n_q); // R4
  AST_WRITE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CASL && cur_we) |-> ((~cas_n_q & ~cur_be) == '0)); // R6
  AST_WE_DRIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> oe_q); // R6
  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |-> (ras_n_q && cas_all_hi && busy)); // R9
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_all_hi |-> !ras_n_q); // R2
endmodule

// File: tb/tb_edo_dram_ctrl.sv
module tb_edo_dram_ctrl;
  localparam int T_RCD = 2, T_RAC = 6, T_CAC = 2, T_CP = 1, T_HPC = 3;
  localparam int T_RP = 4, T_RAS_MIN = 6, T_RASP_MAX = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0, refresh_req = 1'b0;
  logic [21:0] req_addr = '0;
  logic [35:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic [35:0] dq_in = '0;
  logic busy, rd_valid, dram_ras_n, dram_we_n, dram_dq_oe;
  logic [35:0] rd_data, dram_dq_out;
  logic [10:0] dram_a;
  logic [3:0]  dram_cas_n;

  always #5 clk = ~clk;

  edo_dram_ctrl #(.T_RASP_MAX(T_RASP_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .refresh_req(refresh_req), .busy(busy),
    .rd_data(rd_data), .rd_valid(rd_valid), .dram_a(dram_a), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_in));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw, input logic [3:0] m);
    logic [35:0] r = old;
    for (int l = 0; l < 4; l++) if (m[l]) r[l*9 +: 9] = nw[l*9 +: 9];
    return r;
  endfunction

  // Host-side reference: what each address should hold, reads in order.
  logic [35:0] ref_mem [logic [21:0]];
  logic [35:0] rq [$];
  // Array-side model driven only by the strobes.
  logic [35:0] dram_mem [logic [21:0]];
  logic [10:0] exp_row = '0, exp_col = '0, row_l = '0, col_l = '0;
  logic [3:0]  exp_lanes = 4'hf;
  int ras_falls = 0, cas_falls = 0;

  function automatic logic [35:0] ref_rd(input logic [21:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 36'h0;
  endfunction

  // Pin monitor and array model, sampled away from the active edge.
  logic prev_ras = 1'b1, prev_cas_hi = 1'b1, fall_was_rd = 1'b0;
  int ras_lvl = 1000, cas_lvl = 1000, since_ras = 1000, since_cas = 1000;
  always @(negedge clk) begin
    if (rst_n) begin
      int ras_prior, cas_prior;
      logic cas_hi;
      cas_hi = &dram_cas_n;
      since_ras++; since_cas++;
      ras_prior = ras_lvl; cas_prior = cas_lvl;
      if (dram_ras_n == prev_ras) ras_lvl++; else ras_lvl = 1;
      if (cas_hi == prev_cas_hi) cas_lvl++; else cas_lvl = 1;
      if (!dram_ras_n && prev_ras) begin
        chk(ras_prior >= T_RP, "R5 ras high time", ras_prior, T_RP);
        chk(dram_a == exp_row, "R2 row address", dram_a, exp_row);
        row_l = dram_a; since_ras = 0; ras_falls++;
      end
      if (dram_ras_n && !prev_ras)
        chk(ras_prior >= T_RAS_MIN, "R11 ras low time", ras_prior, T_RAS_MIN);
      if (!dram_ras_n)
        chk(ras_lvl <= T_RASP_MAX, "R8 open page time", ras_lvl, T_RASP_MAX);
      if (!cas_hi && prev_cas_hi) begin
        chk(!dram_ras_n, "R2 cas under ras", dram_ras_n, 0);
        chk(since_ras >= T_RCD, "R2 ras to cas", since_ras, T_RCD);
        chk(cas_prior >= T_CP, "R7 cas precharge", cas_prior, T_CP);
        chk(since_cas >= T_HPC, "R7 page cycle", since_cas, T_HPC);
        chk(dram_a == exp_col, "R2 column address", dram_a, exp_col);
        chk(~dram_cas_n == exp_lanes, "R6 lane strobes", ~dram_cas_n, exp_lanes);
        col_l = dram_a; since_cas = 0; cas_falls++;
        fall_was_rd = dram_we_n;
        if (!dram_we_n) begin
          logic [21:0] k;
          k = {row_l, col_l};
          chk(dram_dq_oe, "R6 data enable", dram_dq_oe, 1);
          dram_mem[k] = merge(dram_mem.exists(k) ? dram_mem[k] : 36'h0, dram_dq_out, ~dram_cas_n);
        end
        dq_in = dram_mem.exists({row_l, col_l}) ? dram_mem[{row_l, col_l}] : 36'h0;
      end
      if (cas_hi && !prev_cas_hi && fall_was_rd) begin
        chk(since_ras >= T_RAC, "R3 access from ras", since_ras, T_RAC);
        chk(cas_prior >= T_CAC, "R3 access from cas", cas_prior, T_CAC);
      end
      if (rd_valid) begin
        if (rq.size() == 0) chk(1'b0, "R3 unexpected rd_valid", 1, 0);
        else begin
          logic [35:0] e;
          e = rq.pop_front();
          chk(rd_data == e, "R3 read data", rd_data, e);
        end
      end
      prev_ras = dram_ras_n; prev_cas_hi = cas_hi;
    end
  end

  task automatic issue(input bit w, input logic [21:0] a, input logic [35:0] d, input logic [3:0] b);
    while (busy || refresh_req) @(negedge clk);
    req = 1'b1; req_we = w; req_addr = a; req_wdata = d; req_be = b;
    exp_row = a[21:11]; exp_col = a[10:0];
    exp_lanes = w ? b : 4'hf;
    if (w) ref_mem[a] = merge(ref_rd(a), d, b);
    else rq.push_back(ref_rd(a));
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy || rq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n == 4'hf && dram_we_n, "R1 strobes in reset", {dram_ras_n, dram_cas_n, dram_we_n}, 6'h3f);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n == 4'hf && dram_we_n, "R1 strobes after reset", {dram_ras_n, dram_cas_n, dram_we_n}, 6'h3f);
    chk(!busy && !rd_valid, "R1 busy and valid", {busy, rd_valid}, 0);

    begin : page_hits
      int f0;
      f0 = ras_falls;
      issue(1, {11'd5, 11'd3}, 36'h123456789, 4'hf);
      issue(0, {11'd5, 11'd3}, 0, 0);
      issue(1, {11'd5, 11'd4}, 36'hABCDEF012, 4'hf);
      issue(0, {11'd5, 11'd4}, 0, 0);
      issue(0, {11'd5, 11'd3}, 0, 0);
      drain();
      chk(ras_falls - f0 == 1, "R4 one row open for same-row run", ras_falls - f0, 1);
      chk(!dram_ras_n, "R4 page stays open", dram_ras_n, 0);
    end

    begin : row_miss
      int f0;
      f0 = ras_falls;
      issue(1, {11'd9, 11'd1}, 36'hFEDCBA987, 4'hf);
      issue(0, {11'd9, 11'd1}, 0, 0);
      issue(0, {11'd5, 11'd3}, 0, 0);
      drain();
      chk(ras_falls - f0 == 2, "R5 reopen on row change", ras_falls - f0, 2);
    end

    begin : lanes
      int c0;
      issue(1, {11'd9, 11'd1}, 36'h000000000, 4'b0101);
      issue(0, {11'd9, 11'd1}, 0, 0);
      drain();
      c0 = cas_falls;
      issue(1, {11'd9, 11'd1}, 36'h111111111, 4'b0000);
      drain();
      chk(cas_falls == c0, "R6 empty lane mask strobes nothing", cas_falls - c0, 0);
      issue(0, {11'd9, 11'd1}, 0, 0);
      drain();
    end

    begin : ignored
      issue(0, {11'd200, 11'd7}, 0, 0);
      @(negedge clk);
      if (busy) begin
        req = 1'b1; req_we = 1'b1; req_addr = {11'd9, 11'd1}; req_wdata = 36'h777777777; req_be = 4'hf;
        @(negedge clk);
        req = 1'b0;
      end
      drain();
      issue(0, {11'd9, 11'd1}, 0, 0);
      drain();
      chk(rq.size() == 0, "R10 ignored request left data intact", rq.size(), 0);
    end

    begin : refresh
      int f0;
      issue(0, {11'd9, 11'd1}, 0, 0);
      drain();
      refresh_req = 1'b1;
      repeat (12) @(negedge clk);
      for (int i = 0; i < 6; i++) begin
        chk(dram_ras_n && dram_cas_n == 4'hf && busy, "R9 quiet during refresh",
            {dram_ras_n, dram_cas_n, busy}, 6'h3f);
        @(negedge clk);
      end
      f0 = ras_falls;
      refresh_req = 1'b0;
      issue(0, {11'd9, 11'd1}, 0, 0);
      drain();
      chk(ras_falls - f0 == 1, "R9 row reopened after refresh", ras_falls - f0, 1);
    end

    begin : expiry
      issue(0, {11'd5, 11'd4}, 0, 0);
      drain();
      repeat (T_RASP_MAX + 20) @(negedge clk);
      chk(dram_ras_n, "R8 idle page closed", dram_ras_n, 1);
    end

    for (int i = 0; i < 12; i++) begin
      logic [21:0] a;
      a = {((i % 3) == 0) ? 11'd700 : 11'd33, 11'(i * 7 + 2)};
      issue(1, a, 36'(64'h5A5A00000 ^ (i * 36'h10F0F1)), 4'hf);
    end
    for (int i = 11; i >= 0; i--) begin
      issue(0, {((i % 3) == 0) ? 11'd700 : 11'd33, 11'(i * 7 + 2)}, 0, 0);
    end
    drain();
    chk(rq.size() == 0, "R3 every read returned", rq.size(), 0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R3 watchdog expired", 0, 1);
      finish_run();
    end
  end
endmodule